// File: doc/BRIEF.md
# Ramp-Compare Conversion Capture Timer

This block holds the digital side of a four-channel single-slope converter whose reference ramp restarts with every PWM period. A 12-bit time base is held at zero while the PWM sync pulse is high and starts counting when the pulse ends, so it runs together with the ramp. Each channel watches one external comparator. The first time that comparator rises in a period, the count at that moment is captured as the channel's conversion result. The capture goes into a working (master) register.

On each rising edge of sync, the four master values move at once into readable shadow registers. Software therefore always reads the conversion made in the previous period, while the next one is being captured. A channel whose comparator never trips during a period reports the reserved code 0xFFF0, meaning its input is above the ramp peak. A valid flag marks when the shadow contents are meaningful: the transfer at the first sync edge after reset is not. There are three main channels and one auxiliary channel. All four are also readable through a selected read port.

Top module: `ramp_capture_timer`

## Requirements
- R1: With `fast_count_i` = 1 the time base advances on every clock. With `fast_count_i` = 0 it advances on every second clock. After n clock edges with sync low, the count is n (fast) or floor(n/2) (slow).
- R2: The time base is held at zero on every clock edge where `pwm_sync_i` is high. Counting starts at the first edge where sync is low.
- R3: Each of the four comparator inputs (index 0..2 main, 3 auxiliary) passes through a two-flop synchronizer. If a comparator is first sampled high at edge n of the period (edge 0 is the first edge with sync low), the captured count is the time-base value after n+2 edges.
- R4: On a comparator's captured rising edge, that channel's master register takes the current time-base value.
- R5: On each rising edge of `pwm_sync_i`, all four shadow registers load together from the master registers. At all other times they hold their value, so reads return the previous period's result.
- R6: A channel with no captured comparator rise during a period reports 0xFFF0 after the next sync rising edge.
- R7: The time base saturates at 4095 and never wraps.
- R8: `valid_o` is 0 after reset and after the first sync rising edge. It is 1 from the second sync rising edge onward.
- R9: Only the first comparator rise in a period is captured. Later rises in the same period leave the result unchanged.
- R10: A normal result carries the 12-bit count in bits 15:4, with bits 3:0 zero.
- R11: `rd_data_o` presents the shadow register of the channel chosen by `rd_sel_i`, combinationally (0..2 main, 3 auxiliary).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_sync_i | input | 1 | PWM period sync pulse, high at period start |
| cmp_i | input | 4 | Comparator outputs, asynchronous |
| fast_count_i | input | 1 | Count rate select: 1 every clock, 0 every second clock |
| rd_sel_i | input | 2 | Channel select for `rd_data_o` |
| res_main0_o | output | 16 | Shadow result, main channel 0 |
| res_main1_o | output | 16 | Shadow result, main channel 1 |
| res_main2_o | output | 16 | Shadow result, main channel 2 |
| res_aux_o | output | 16 | Shadow result, auxiliary channel |
| rd_data_o | output | 16 | Selected shadow result |
| valid_o | output | 1 | Shadow results are meaningful |

## Verification
The assertions assume `pwm_sync_i` is a synchronous signal from the same clock domain. They also assume the rate select stays constant while a ramp is counting. The stimulus changes `fast_count_i` only while sync is high. It brings every comparator low during the sync pulse. It places each comparator rise, including deliberate retrigger glitches, at least three edges before the closing sync edge, so that no capture collides with a shadow transfer. Expected results are computed from the edge index of each rise, the rate and the saturation limit. Both rates are swept across many rise positions and across the saturation boundary.

// File: rtl/rct_pkg.sv
package rct_pkg;
  localparam int CNT_W = 12;
  localparam int RES_W = 16;
  localparam int PAD_W = RES_W - CNT_W;
  localparam int N_CH  = 4;
  localparam logic [RES_W-1:0] OVR_CODE = 16'hFFF0;

  typedef logic [CNT_W-1:0] count_t;
  typedef logic [RES_W-1:0] result_t;

  // Saturating increment of the time base
  function automatic count_t rct_next(input count_t c);
    return (c == '1) ? c : c + 1'b1;
  endfunction

  // Result word from a captured count and its hit flag
  function automatic result_t rct_format(input count_t c, input logic hit);
    if (hit) return {c, {PAD_W{1'b0}}};
    return OVR_CODE;
  endfunction
endpackage

// File: rtl/rct_sync.sv
module rct_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rct_timebase.sv
module rct_timebase
  import rct_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_i,
  input  logic   fast_i,
  output count_t cnt_o
);
  count_t cnt_q;
  logic   phase_q;
  logic   tick;

  assign tick = fast_i | phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (sync_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      if (tick) cnt_q <= rct_next(cnt_q);
    end
  end

  assign cnt_o = cnt_q;

  assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> cnt_q == '0);
  assert_fast_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && fast_i && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && cnt_q == '1) |=> cnt_q == '1);
endmodule

// File: rtl/rct_channel.sv
module rct_channel
  import rct_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmp_s_i,
  input  logic    sync_rise_i,
  input  count_t  cnt_i,
  output result_t shadow_o
);
  logic   cmp_d_q;
  logic   captured_q;
  count_t master_q;
  logic   cmp_rise;
  logic   take;

  assign cmp_rise = cmp_s_i & ~cmp_d_q;
  assign take     = cmp_rise & (sync_rise_i | ~captured_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_d_q    <= 1'b0;
      captured_q <= 1'b0;
      master_q   <= '0;
      shadow_o   <= '0;
    end else begin
      cmp_d_q <= cmp_s_i;
      if (take) master_q <= cnt_i;
      if (sync_rise_i) begin
        shadow_o   <= rct_format(master_q, captured_q);
        captured_q <= cmp_rise;
      end else begin
        captured_q <= captured_q | cmp_rise;
      end
    end
  end

  assert_capture_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> master_q == $past(cnt_i));
  assert_first_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (captured_q && !sync_rise_i) |=> $stable(master_q));
  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_rise_i |=> $stable(shadow_o));
  assert_overvoltage_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise_i && !captured_q) |=> shadow_o == OVR_CODE);
endmodule

// File: rtl/ramp_capture_timer.sv
module ramp_capture_timer
  import rct_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_sync_i,
  input  logic [N_CH-1:0]  cmp_i,
  input  logic             fast_count_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [RES_W-1:0] res_main0_o,
  output logic [RES_W-1:0] res_main1_o,
  output logic [RES_W-1:0] res_main2_o,
  output logic [RES_W-1:0] res_aux_o,
  output logic [RES_W-1:0] rd_data_o,
  output logic             valid_o
);
  logic            sync_q;
  logic            sync_rise;
  logic            seen_q;
  logic            valid_q;
  count_t          cnt;
  logic [N_CH-1:0] cmp_s;
  result_t         shadow [N_CH];

  assign sync_rise = pwm_sync_i & ~sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      sync_q <= pwm_sync_i;
      if (sync_rise) begin
        seen_q <= 1'b1;
        if (seen_q) valid_q <= 1'b1;
      end
    end
  end

  rct_timebase u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (pwm_sync_i),
    .fast_i (fast_count_i),
    .cnt_o  (cnt)
  );

  rct_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      rct_channel u_ch (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_s_i     (cmp_s[c]),
        .sync_rise_i (sync_rise),
        .cnt_i       (cnt),
        .shadow_o    (shadow[c])
      );
    end
  endgenerate

  assign res_main0_o = shadow[0];
  assign res_main1_o = shadow[1];
  assign res_main2_o = shadow[2];
  assign res_aux_o   = shadow[3];
  assign rd_data_o   = shadow[rd_sel_i];
  assign valid_o     = valid_q;

  assert_valid_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !(sync_rise && seen_q)) |=> !valid_q);
  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);
endmodule

// File: tb/ramp_capture_timer_test.sv
module ramp_capture_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sync;
  logic [3:0]  cmp;
  logic        fast;
  logic [1:0]  sel;
  logic [15:0] r0, r1, r2, r3, rd;
  logic        valid;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ramp_capture_timer uut (
    .clk(clk), .rst_n(rst_n), .pwm_sync_i(sync), .cmp_i(cmp),
    .fast_count_i(fast), .rd_sel_i(sel),
    .res_main0_o(r0), .res_main1_o(r1), .res_main2_o(r2), .res_aux_o(r3),
    .rd_data_o(rd), .valid_o(valid)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R1 R3 R7 R10 R6: expected result from rise edge index d (-1: never)
  function automatic logic [15:0] expect_res(input bit f, input int d);
    int n;
    if (d < 0) return 16'hFFF0;
    n = f ? d + 2 : (d + 2) / 2;
    if (n > 4095) n = 4095;
    return {n[11:0], 4'h0};
  endfunction

  // Entered at a negedge with sync high for one edge already applied
  task automatic run_period(input bit f, input int len, input int d0, input int d1,
                            input int d2, input int d3, input int g, input bit do_check);
    int d [4];
    logic [15:0] outs [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    fast = f;
    @(negedge clk);
    @(negedge clk);
    sync = 1'b0;
    for (int t = 0; t < len; t++) begin
      for (int c = 0; c < 4; c++) begin
        logic v;
        v = (d[c] >= 0) && (t >= d[c]);
        if (c == g && d[c] >= 0 && t >= d[c] + 4 && t < d[c] + 6) v = 1'b0; // R9 retrigger
        cmp[c] = v;
      end
      @(negedge clk);
    end
    sync = 1'b1;
    cmp  = 4'b0;
    @(negedge clk);
    if (do_check) begin
      outs[0] = r0; outs[1] = r1; outs[2] = r2; outs[3] = r3;
      for (int c = 0; c < 4; c++) begin
        check("R3/R4/R5/R6/R9/R10 channel result", outs[c], expect_res(f, d[c]));
        sel = c[1:0];
        #1;
        check("R11 read select", rd, expect_res(f, d[c]));
      end
      check("R8 valid high", {15'd0, valid}, 16'd1);
    end
  endtask

  initial begin
    rst_n = 1'b0; sync = 1'b0; cmp = 4'b0; fast = 1'b1; sel = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R8 reset valid", {15'd0, valid}, 16'd0);
    check("R5 reset shadow", r0 | r1 | r2 | r3, 16'h0000);
    @(negedge clk);
    sync = 1'b1;
    @(negedge clk);
    check("R8 valid low after first sync", {15'd0, valid}, 16'd0);
    // first period: values are transferred at the second sync edge
    run_period(1'b1, 40, 3, 8, -1, 12, 0, 1'b0);
    check("R8 valid after second sync", {15'd0, valid}, 16'd1);
    // sweep: both rates, many rise positions; d=0 checks R2 start point
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 10; k++) begin
        run_period(f[0], 40, k, 3*k + 1, (k % 3 == 0) ? -1 : 30 - k, 2*k + 5, k % 4, 1'b1);
      end
    end
    // R7 saturation, fast rate
    run_period(1'b1, 4200, 4150, 4093, 4094, -1, 3, 1'b1);
    // R7 saturation, slow rate
    run_period(1'b0, 8400, 8300, 8188, 8187, 100, 0, 1'b1);
    // R5 hold: no sync edge, shadows keep last period's results
    repeat (20) @(negedge clk);
    check("R5 shadow hold main0", r0, expect_res(1'b0, 8300));
    check("R5 shadow hold aux", r3, expect_res(1'b0, 100));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule